// File: doc/BRIEF.md
# HDLC Frame Receiver with Per-Byte Completion Status

This block recovers HDLC frames from a serial bit stream that arrives with a one-cycle bit enable. It finds the opening and closing flags and removes the zeros that were stuffed into the data. It detects aborts and checks the CRC-16 frame check sequence. Every recovered octet is stored in a small receive FIFO, and the frame check bytes are stored too. Each stored octet carries a first-of-message tag, a last-of-message tag and a 3-bit completion code.

A host pops octets through a simple read port. After each pop the port shows the octet and its completion code. The code is zero for every octet except the last one of a message, which carries the outcome of that message. A real-time empty flag tells the host when the FIFO holds nothing. A first-byte indicator is high while the octet at the head of the FIFO opens a new message.

The receiver keeps the newest octet in a holding register until it knows whether more data follows. This lets the last octet of a message take its tag and code at the moment the message ends. A message ends on a closing flag, an abort, or a FIFO overrun.

Top module: `hdlc_rx_status`

## Requirements
- R1: Octets between an opening and a closing flag (pattern 0x7E) are stored in arrival order, each assembled least significant bit first. The two frame check octets are stored as well. Flags with no octets between them store nothing.
- R2: Inside a frame, a 0 that follows five consecutive 1s is dropped before octet assembly. This lets payload octets 0xFF and 0x7E arrive intact.
- R3: Completion codes on `rd_status`: 000 in progress, 001 good, 010 CRC error, 011 abort, 100 overrun, 101 too short. A read of an octet that is not the last of its message shows 000. A message closed by a flag reads 001 on its last octet when the CRC-16 (polynomial x^16+x^12+x^5+1, preset 0xFFFF, LSB-first) over data plus check octets leaves the residue 0xF0B8.
- R4: A message closed by a flag whose residue differs from 0xF0B8 reads 010 on its last octet.
- R5: Seven consecutive 1s end the current message. The last stored octet reads 011, and all input is then ignored until the next flag.
- R6: A message of three or fewer octets, counting the check octets, reads 101 on its last octet whatever its CRC.
- R7: If an octet must be stored while only one FIFO slot is free, that octet is stored as the last one of the message with code 100. The rest of the message is discarded until the next flag.
- R8: `rx_empty` is high exactly when the FIFO holds no octets. A read while it is empty leaves `rd_data` and `rd_status` unchanged.
- R9: `open_evt` is high while the octet at the head of the FIFO is the first octet of a message.
- R10: After reset `rx_empty` is 1 and `rd_data`, `rd_status` and `open_evt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| rd_en | input | 1 | Pop one octet from the FIFO |
| rd_data | output | 8 | Octet returned by the latest pop |
| rd_status | output | 3 | Completion code of the latest popped octet |
| rx_empty | output | 1 | FIFO holds no octets |
| open_evt | output | 1 | Head octet opens a message |

## Verification
On every cycle the assertions check several properties. A read of an empty FIFO leaves the read outputs frozen. The completion code stays within the six legal values. The first-byte indicator never rises over an empty FIFO. An octet that does not end its message is never written with a nonzero code. The FIFO is never written when it is full. An abort-coded write occurs only on the seventh consecutive raw 1. Only the bench scenarios can show that whole messages come back intact and in order after zero removal, and that the CRC, too-short and overrun outcomes land on the correct octet. They also show that input after an abort or overrun is really discarded.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [2:0] {
        ST_PROGRESS = 3'd0,
        ST_GOOD     = 3'd1,
        ST_CRCERR   = 3'd2,
        ST_ABORT    = 3'd3,
        ST_OVERRUN  = 3'd4,
        ST_SHORT    = 3'd5
    } rx_status_e;

    typedef struct packed {
        logic [7:0] data;
        logic       som;
        logic       eom;
        rx_status_e status;
    } rx_entry_t;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_R  = 16'h8408;

    function automatic logic [15:0] crc_octet(input logic [15:0] crc_in, input logic [7:0] oct);
        logic [15:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ oct[i]) c = (c >> 1) ^ CRC_POLY_R;
            else               c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_en,
    input  logic      bit_in,
    input  logic      room_last,
    input  logic      room_none,
    output logic      wr_en,
    output rx_entry_t wr_entry
);

    typedef enum logic {PH_HUNT, PH_FRAME} phase_e;

    typedef struct packed {
        phase_e      phase;
        logic [2:0]  ones;
        logic [7:0]  shreg;
        logic [2:0]  bit_cnt;
        logic [7:0]  held;
        logic        held_v;
        logic        held_som;
        logic [2:0]  oct_cnt;
        logic [15:0] crc;
    } dfr_state_t;

    dfr_state_t q, d;
    logic       take_bit;
    logic       data_bit;
    logic [7:0] new_oct;

    always_comb begin
        d        = q;
        wr_en    = 1'b0;
        wr_entry = '0;
        take_bit = 1'b0;
        data_bit = bit_in;
        new_oct  = {bit_in, q.shreg[7:1]};

        if (bit_en) begin
            if (bit_in) begin
                d.ones = (q.ones == 3'd7) ? 3'd7 : q.ones + 3'd1;
                if (q.ones == 3'd6) begin
                    if (q.phase == PH_FRAME && q.held_v && !room_none) begin
                        wr_en    = 1'b1;
                        wr_entry = '{data: q.held, som: q.held_som, eom: 1'b1, status: ST_ABORT};
                    end
                    d.phase  = PH_HUNT;
                    d.held_v = 1'b0;
                end else if (q.phase == PH_FRAME) begin
                    take_bit = 1'b1;
                end
            end else begin
                d.ones = 3'd0;
                if (q.ones == 3'd6) begin
                    if (q.phase == PH_FRAME && q.held_v && !room_none) begin
                        wr_en    = 1'b1;
                        wr_entry = '{data: q.held, som: q.held_som, eom: 1'b1,
                                     status: (q.oct_cnt <= 3'd3) ? ST_SHORT :
                                             (q.crc == CRC_RESIDUE) ? ST_GOOD : ST_CRCERR};
                    end
                    d.phase   = PH_FRAME;
                    d.bit_cnt = 3'd0;
                    d.oct_cnt = 3'd0;
                    d.crc     = CRC_PRESET;
                    d.held_v  = 1'b0;
                end else if (q.ones != 3'd5 && q.phase == PH_FRAME) begin
                    take_bit = 1'b1;
                end
            end
        end

        if (take_bit) begin
            d.shreg   = {data_bit, q.shreg[7:1]};
            d.bit_cnt = q.bit_cnt + 3'd1;
            if (q.bit_cnt == 3'd7) begin
                d.crc      = crc_octet(q.crc, new_oct);
                d.oct_cnt  = (q.oct_cnt == 3'd4) ? 3'd4 : q.oct_cnt + 3'd1;
                d.held     = new_oct;
                d.held_v   = 1'b1;
                d.held_som = (q.oct_cnt == 3'd0);
                if (q.held_v) begin
                    if (room_none) begin
                        d.phase  = PH_HUNT;
                        d.held_v = 1'b0;
                    end else if (room_last) begin
                        wr_en    = 1'b1;
                        wr_entry = '{data: q.held, som: q.held_som, eom: 1'b1, status: ST_OVERRUN};
                        d.phase  = PH_HUNT;
                        d.held_v = 1'b0;
                    end else begin
                        wr_en    = 1'b1;
                        wr_entry = '{data: q.held, som: q.held_som, eom: 1'b0, status: ST_PROGRESS};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_HUNT;
            q.crc   <= CRC_PRESET;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  rx_entry_t  wr_entry,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic [2:0] rd_status,
    output logic       empty,
    output logic       full,
    output logic       last_slot,
    output logic       head_som
);

    localparam int unsigned AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] CNT_FULL = (AW + 1)'(DEPTH);
    localparam logic [AW:0] CNT_LAST = (AW + 1)'(DEPTH - 1);
    localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [AW:0]           cnt;
        logic [7:0]            rdat;
        logic [2:0]            rst;
    } fifo_state_t;

    fifo_state_t q, d;
    logic        push, pop;
    rx_entry_t   head;

    assign head      = q.mem[q.rp];
    assign empty     = (q.cnt == '0);
    assign full      = (q.cnt == CNT_FULL);
    assign last_slot = (q.cnt == CNT_LAST);
    assign head_som  = !empty && head.som;
    assign rd_data   = q.rdat;
    assign rd_status = q.rst;

    always_comb begin
        d    = q;
        push = wr_en && !full;
        pop  = rd_en && !empty;
        if (push) begin
            d.mem[q.wp] = wr_entry;
            d.wp        = (q.wp == PTR_MAX) ? '0 : q.wp + 1'b1;
        end
        if (pop) begin
            d.rp   = (q.rp == PTR_MAX) ? '0 : q.rp + 1'b1;
            d.rdat = head.data;
            d.rst  = head.eom ? head.status : ST_PROGRESS;
        end
        d.cnt = q.cnt + (AW + 1)'(push) - (AW + 1)'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic [2:0] rd_status,
    output logic       rx_empty,
    output logic       open_evt
);

    logic      wr_en;
    rx_entry_t wr_entry;
    logic      fifo_full;
    logic      fifo_last;

    hdlc_rx_deframer u_dfr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .room_last (fifo_last),
        .room_none (fifo_full),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry)
    );

    hdlc_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .rd_status (rd_status),
        .empty     (rx_empty),
        .full      (fifo_full),
        .last_slot (fifo_last),
        .head_som  (open_evt)
    );

endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk
    import hdlc_rx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       bit_in,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic [2:0] rd_status,
    input logic       rx_empty,
    input logic       open_evt,
    input logic       wr_en,
    input rx_entry_t  wr_entry,
    input logic       fifo_full
);

    logic [2:0] raw_ones;

    always_ff @(posedge clk) begin
        if (!rst_n)                raw_ones <= 3'd0;
        else if (bit_en && bit_in) raw_ones <= (raw_ones == 3'd7) ? 3'd7 : raw_ones + 3'd1;
        else if (bit_en)           raw_ones <= 3'd0;
    end

    assert_read_empty_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rx_empty |=> $stable(rd_data) && $stable(rd_status));

    assert_status_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status <= 3'd5);

    assert_open_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        open_evt |-> !rx_empty);

    assert_mid_code_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_entry.eom |-> wr_entry.status == ST_PROGRESS);

    assert_no_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !fifo_full);

    assert_abort_on_seventh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_entry.status == ST_ABORT |-> bit_en && bit_in && raw_ones == 3'd6);

endmodule

bind hdlc_rx_status hdlc_rx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_status (rd_status),
    .rx_empty  (rx_empty),
    .open_evt  (open_evt),
    .wr_en     (wr_en),
    .wr_entry  (wr_entry),
    .fifo_full (fifo_full)
);

// File: tb/hdlc_rx_status_tb.sv
module hdlc_rx_status_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       mon_rd = 1'b0;
    logic       tb_rd = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] rd_status;
    logic       rx_empty;
    logic       open_evt;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int tx_ones = 0;
    bit reader_on = 1'b1;
    bit rd_pend = 1'b0;

    logic [7:0] fr_q[$];
    logic [7:0] exp_data[$];
    logic [2:0] exp_st[$];
    logic       exp_som[$];
    string      exp_tag[$];

    always #10 clk = ~clk;

    hdlc_rx_status dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .rd_en(mon_rd | tb_rd), .rd_data(rd_data), .rd_status(rd_status),
        .rx_empty(rx_empty), .open_evt(open_evt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c0, input logic [7:0] b);
        logic [15:0] c = c0;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ b[i]) c = (c >> 1) ^ 16'h8408;
            else             c = c >> 1;
        end
        return c;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // monitor: pops FIFO and compares against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_pend) begin
                rd_pend = 1'b0;
                if (exp_data.size() != 0) begin
                    check(rd_data == exp_data[0], {exp_tag[0], " data"}, rd_data, exp_data[0]);
                    check(rd_status == exp_st[0], {exp_tag[0], " status"}, rd_status, exp_st[0]);
                    void'(exp_data.pop_front());
                    void'(exp_st.pop_front());
                    void'(exp_som.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
            mon_rd = 1'b0;
            if (reader_on && !rx_empty) begin
                if (exp_data.size() == 0) begin
                    check(1'b0, "R1 unexpected octet", 1, 0);
                end else begin
                    check(open_evt == exp_som[0], {exp_tag[0], " open_evt R9"}, open_evt, exp_som[0]);
                end
                mon_rd  = 1'b1;
                rd_pend = 1'b1;
            end
        end
    end

    task automatic drive_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bit_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_flag();
        drive_bit(1'b0);
        repeat (6) drive_bit(1'b1);
        drive_bit(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_data_bit(input logic b);
        drive_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                drive_bit(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_octet(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_data_bit(v[i]);
    endtask

    task automatic expect_octets(input int keep, input logic [2:0] st, input string tag);
        for (int i = 0; i < keep; i++) begin
            exp_data.push_back(fr_q[i]);
            exp_st.push_back((i == keep - 1) ? st : 3'd0);
            exp_som.push_back(i == 0);
            exp_tag.push_back(tag);
        end
    endtask

    // fr_q holds payload; check octets are appended here
    task automatic send_frame(input logic [2:0] st, input bit bad, input int keep, input string tag);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] fcs;
        int n;
        foreach (fr_q[i]) c = ref_crc(c, fr_q[i]);
        fcs = ~c ^ {15'd0, bad};
        fr_q.push_back(fcs[7:0]);
        fr_q.push_back(fcs[15:8]);
        n = (keep == 0) ? fr_q.size() : keep;
        expect_octets(n, st, tag);
        send_flag();
        foreach (fr_q[i]) send_octet(fr_q[i]);
        send_flag();
        idle(2);
    endtask

    task automatic drain();
        while (exp_data.size() != 0 || !rx_empty) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [7:0] keep_d;
        logic [2:0] keep_s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(rx_empty == 1'b1, "R10 rx_empty", rx_empty, 1);
        check(rd_data == 8'h00, "R10 rd_data", rd_data, 0);
        check(rd_status == 3'd0, "R10 rd_status", rd_status, 0);
        check(open_evt == 1'b0, "R10 open_evt", open_evt, 0);

        // R1 R3: good frame, code 001 on last octet
        fr_q = '{8'h12, 8'h34, 8'h56, 8'h78};
        send_frame(3'd1, 1'b0, 0, "R1 R3 good");
        drain();

        // R2: payload needing zero insertion
        fr_q = '{8'hFF, 8'h7E, 8'h3F, 8'hFC, 8'hF8};
        send_frame(3'd1, 1'b0, 0, "R2 stuffing");
        drain();

        // R4: corrupted check octets
        fr_q = '{8'hA5, 8'h5A, 8'hC3};
        send_frame(3'd2, 1'b1, 0, "R4 crc error");
        drain();

        // R6: three octets total, good CRC still reads too short
        fr_q = '{8'h9C};
        send_frame(3'd5, 1'b0, 0, "R6 too short");
        drain();
        // R6: three octets total with bad CRC also too short
        fr_q = '{8'h21};
        send_frame(3'd5, 1'b1, 0, "R6 short bad crc");
        drain();

        // R1: back-to-back flags store nothing
        send_flag(); send_flag(); send_flag();
        idle(4);
        check(rx_empty == 1'b1, "R1 empty after bare flags", rx_empty, 1);

        // R5: abort after three octets, then garbage ignored until a flag
        fr_q = '{8'h11, 8'h22, 8'h33};
        expect_octets(3, 3'd3, "R5 abort");
        send_flag();
        foreach (fr_q[i]) send_octet(fr_q[i]);
        repeat (8) drive_bit(1'b1);
        repeat (16) drive_bit(1'b0);
        idle(2);
        drain();
        fr_q = '{8'h44, 8'h55, 8'h66, 8'h77};
        send_frame(3'd1, 1'b0, 0, "R5 after abort");
        drain();

        // R7: overrun with reader stopped, DEPTH 8 -> seven normal, eighth coded 100
        reader_on = 1'b0;
        fr_q.delete();
        for (int i = 0; i < 12; i++) fr_q.push_back(8'(i * 17 + 1));
        send_frame(3'd4, 1'b0, 8, "R7 overrun");
        idle(2);
        check(rx_empty == 1'b0, "R8 rx_empty low while filled", rx_empty, 0);
        reader_on = 1'b1;
        drain();
        check(rx_empty == 1'b1, "R8 rx_empty high after drain", rx_empty, 1);

        // R8: read while empty changes nothing
        keep_d = rd_data;
        keep_s = rd_status;
        reader_on = 1'b0;
        @(negedge clk); tb_rd = 1'b1;
        @(negedge clk); tb_rd = 1'b0;
        @(negedge clk);
        check(rd_data == keep_d, "R8 data held on empty read", rd_data, keep_d);
        check(rd_status == keep_s, "R8 status held on empty read", rd_status, keep_s);
        reader_on = 1'b1;

        // R7 recovery: next frame received normally
        fr_q = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
        send_frame(3'd1, 1'b0, 0, "R7 recovery");
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule